// File: doc/BRIEF.md
# Iterative Feistel Block Encryption Engine

This block encrypts one 64-bit block under a 64-bit key with the classic sixteen-round Feistel data encryption algorithm. It computes one round per clock cycle and reuses the same round hardware each time. A single-cycle `start` strobe captures the plaintext and key. The engine then works for sixteen cycles and raises `done` for one cycle. In that same cycle the new ciphertext appears, and it stays on `ciphertext` until the next result replaces it.

The least significant bit of every key byte is a parity bit and is dropped, so 56 key bits are used. Each round takes the right half of the data and widens it from 32 to 48 bits. It XORs that with a 48-bit round subkey and passes the result through eight 6-to-4 substitution boxes. A 32-bit permutation follows, and the output is XORed into the left half before the two halves change places. The key schedule holds two 28-bit halves. It rotates them left by a fixed amount for each round and compresses them to 48 bits to form the subkey.

The controller has two states. IDLE waits for work. ROUND runs one round per cycle. There are three transitions: *accept* (IDLE→ROUND when `start` is high), *iterate* (ROUND→ROUND while rounds remain) and *finish* (ROUND→IDLE on the sixteenth round, which also writes the output register).

Top module: `des_iter_engine`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, `done` is 0 and `ciphertext` is all zeros.
- R2: Key 0123456789ABCDEF encrypts 4E6F772069732074 to 3FA40E8A984D4815, 68652074696D6520 to 6A271787AB8883F9 and 666F7220616C6C20 to 893D51EC4B563B53. Key 133457799BBCDFF1 encrypts 0123456789ABCDEF to 85E813540F0AB405. An all-zero key encrypts an all-zero block to 8CA64DE9C1B123A7.
- R3: If `start` is sampled high in IDLE at clock edge N, `done` is high after edge N+16 and low again after edge N+17. There is exactly one `done` pulse per accepted start.
- R4: A `start` seen in ROUND, including in the cycle that finishes a block, has no effect. It neither restarts nor changes the block in progress, and it creates no extra `done`.
- R5: Bit 0 of every key byte (key bits 0, 8, …, 56) is ignored. Flipping all eight of those bits leaves the ciphertext unchanged.
- R6: `ciphertext` changes only in the cycle in which `done` is high. At all other times it holds its value.
- R7: In a substitution box with input b1..b6 (b1 is the MSB), the row is 2·b1+b6 and the column is b2b3b4b5. Box 8 with input 011011 gives 14. Box 1 with input 110101 gives 3. Box 1 with input 000000 gives 14.
- R8: Key halves rotate left by 1 in rounds 1, 2, 9 and 16 and by 2 in every other round. The halves are not swapped after round 16, so the output is the inverse initial permutation of R16‖L16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe; captures `plaintext` and `key` when the engine is idle |
| plaintext | input | 64 | Block to encrypt |
| key | input | 64 | Key including eight parity bits |
| ciphertext | output | 64 | Last result, held between blocks |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
Two events can fall on the same edge: the finish of one block and a new `start`. Holding `start` high without a break makes the sixteenth round coincide with a request. A correct engine must finish, ignore that request and accept the following one, so results appear 17 cycles apart. A second request that arrives in the middle of a block carries a different plaintext and key. It is judged by checking that only the first block's ciphertext appears, with a single `done`. A cycle-accurate model in the bench predicts `done` and `ciphertext` on every clock.

// File: rtl/des_pkg.sv
package des_pkg;

    localparam int BLK_W  = 64;
    localparam int HALF_W = 32;
    localparam int KEY_W  = 64;
    localparam int KEFF_W = 56;
    localparam int KHALF_W = 28;
    localparam int SUB_W  = 48;
    localparam int NBOX   = 8;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_ROUND = 1'b1
    } fsm_e;

    // Key reduction: entry i names the 1-based source key bit (1 = MSB)
    localparam logic [0:55][7:0] KSEL_TBL = {
        8'd57, 8'd49, 8'd41, 8'd33, 8'd25, 8'd17, 8'd9,  8'd1,
        8'd58, 8'd50, 8'd42, 8'd34, 8'd26, 8'd18, 8'd10, 8'd2,
        8'd59, 8'd51, 8'd43, 8'd35, 8'd27, 8'd19, 8'd11, 8'd3,
        8'd60, 8'd52, 8'd44, 8'd36, 8'd63, 8'd55, 8'd47, 8'd39,
        8'd31, 8'd23, 8'd15, 8'd7,  8'd62, 8'd54, 8'd46, 8'd38,
        8'd30, 8'd22, 8'd14, 8'd6,  8'd61, 8'd53, 8'd45, 8'd37,
        8'd29, 8'd21, 8'd13, 8'd5,  8'd28, 8'd20, 8'd12, 8'd4
    };

    // Subkey compression 56 -> 48
    localparam logic [0:47][7:0] KCMP_TBL = {
        8'd14, 8'd17, 8'd11, 8'd24, 8'd1,  8'd5,  8'd3,  8'd28,
        8'd15, 8'd6,  8'd21, 8'd10, 8'd23, 8'd19, 8'd12, 8'd4,
        8'd26, 8'd8,  8'd16, 8'd7,  8'd27, 8'd20, 8'd13, 8'd2,
        8'd41, 8'd52, 8'd31, 8'd37, 8'd47, 8'd55, 8'd30, 8'd40,
        8'd51, 8'd45, 8'd33, 8'd48, 8'd44, 8'd49, 8'd39, 8'd56,
        8'd34, 8'd53, 8'd46, 8'd42, 8'd50, 8'd36, 8'd29, 8'd32
    };

    // Round output shuffle 32 -> 32
    localparam logic [0:31][7:0] RPERM_TBL = {
        8'd16, 8'd7,  8'd20, 8'd21, 8'd29, 8'd12, 8'd28, 8'd17,
        8'd1,  8'd15, 8'd23, 8'd26, 8'd5,  8'd18, 8'd31, 8'd10,
        8'd2,  8'd8,  8'd24, 8'd14, 8'd32, 8'd27, 8'd3,  8'd9,
        8'd19, 8'd13, 8'd30, 8'd6,  8'd22, 8'd11, 8'd4,  8'd25
    };

    // Substitution boxes: 4 rows x 16 columns, one nibble each, row 0 first
    localparam logic [0:7][255:0] SBOX_TBL = {
        256'hE4D12FB83A6C59070F74E2D1A6CB953841E8D62BFC973A50FC8249175B3EA06D,
        256'hF18E6B34972DC05A3D47F28EC01A69B50E7BA4D158C6932FD8A13F42B67C05E9,
        256'hA09E63F51DC7B428D709346A285ECBF1D6498F30B12C5AE71AD069874FE3B52C,
        256'h7DE3069A1285BC4FD8B56F03472C1AE9A690CB7DF13E52843F06A1D8945BC72E,
        256'h2C417AB6853FD0E9EB2C47D150FA3986421BAD78F9C5630EB8C71E2D6F09A453,
        256'hC1AF92680D34E75BAF427C9561DE0B389EF528C3704A1DB6432C95FABE17608D,
        256'h4B2EF08D3C975A61D0B7491AE35C2F8614BDC37EAF6805926BD814A7950FE23C,
        256'hD2846FB1A93E50C71FD8A374C56B0E927B419CE206ADF35821E74A8DFC90356B
    };

    // Source bit (1-based) of output position i of the entry shuffle
    function automatic int entry_src(input int i);
        int r;
        int c;
        r = i / 8;
        c = i % 8;
        return ((r < 4) ? (58 + 2 * r) : (57 + 2 * (r - 4))) - 8 * c;
    endfunction

    function automatic logic [BLK_W-1:0] entry_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        y = '0;
        for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-entry_src(i)];
        return y;
    endfunction

    function automatic logic [BLK_W-1:0] exit_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        y = '0;
        for (int i = 0; i < BLK_W; i++) y[BLK_W-entry_src(i)] = x[BLK_W-1-i];
        return y;
    endfunction

    function automatic logic [SUB_W-1:0] widen(input logic [HALF_W-1:0] x);
        logic [SUB_W-1:0] y;
        int s;
        y = '0;
        for (int g = 0; g < NBOX; g++) begin
            for (int k = 0; k < 6; k++) begin
                s = 4 * g + k;
                if (s == 0) s = HALF_W;
                if (s == HALF_W + 1) s = 1;
                y[SUB_W-1-(6*g+k)] = x[HALF_W-s];
            end
        end
        return y;
    endfunction

    function automatic logic [HALF_W-1:0] round_shuffle(input logic [HALF_W-1:0] x);
        logic [HALF_W-1:0] y;
        y = '0;
        for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-int'(RPERM_TBL[i])];
        return y;
    endfunction

    function automatic logic [KEFF_W-1:0] key_select(input logic [KEY_W-1:0] x);
        logic [KEFF_W-1:0] y;
        y = '0;
        for (int i = 0; i < KEFF_W; i++) y[KEFF_W-1-i] = x[KEY_W-int'(KSEL_TBL[i])];
        return y;
    endfunction

    function automatic logic [SUB_W-1:0] key_compress(input logic [KEFF_W-1:0] x);
        logic [SUB_W-1:0] y;
        y = '0;
        for (int i = 0; i < SUB_W; i++) y[SUB_W-1-i] = x[KEFF_W-int'(KCMP_TBL[i])];
        return y;
    endfunction

    // Row from outer bits (b1,b6), column from inner bits b2..b5
    function automatic logic [3:0] sbox_val(input int box, input logic [5:0] d);
        int idx;
        idx = int'({d[5], d[0]}) * 16 + int'(d[4:1]);
        return SBOX_TBL[box][255-4*idx -: 4];
    endfunction

    // One-bit rotation in rounds 1, 2, 9, 16 (0-based 0, 1, 8, 15)
    function automatic logic single_step(input int r);
        return (r == 0) || (r == 1) || (r == 8) || (r == 15);
    endfunction

endpackage

// File: rtl/des_key_sched.sv
module des_key_sched
    import des_pkg::*;
#(
    parameter int CTR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [KEY_W-1:0]   key_in,
    input  logic [CTR_W-1:0]   round_idx,
    output logic [SUB_W-1:0]   subkey
);

    logic [KHALF_W-1:0] c_q, d_q;
    logic [KHALF_W-1:0] c_rot, d_rot;
    logic               one_bit;

    assign one_bit = single_step(int'(round_idx));

    always_comb begin
        if (one_bit) begin
            c_rot = {c_q[KHALF_W-2:0], c_q[KHALF_W-1]};
            d_rot = {d_q[KHALF_W-2:0], d_q[KHALF_W-1]};
        end else begin
            c_rot = {c_q[KHALF_W-3:0], c_q[KHALF_W-1 -: 2]};
            d_rot = {d_q[KHALF_W-3:0], d_q[KHALF_W-1 -: 2]};
        end
    end

    assign subkey = key_compress({c_rot, d_rot});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
            d_q <= '0;
        end else if (load) begin
            {c_q, d_q} <= key_select(key_in);
        end else if (step) begin
            c_q <= c_rot;
            d_q <= d_rot;
        end
    end

endmodule

// File: rtl/des_round_fn.sv
module des_round_fn
    import des_pkg::*;
(
    input  logic [HALF_W-1:0] r_in,
    input  logic [SUB_W-1:0]  subkey,
    output logic [HALF_W-1:0] f_out
);

    logic [SUB_W-1:0]  mixed;
    logic [HALF_W-1:0] sub_out;

    assign mixed = widen(r_in) ^ subkey;

    for (genvar g = 0; g < NBOX; g++) begin : g_box
        assign sub_out[HALF_W-1-4*g -: 4] = sbox_val(g, mixed[SUB_W-1-6*g -: 6]);
    end

    assign f_out = round_shuffle(sub_out);

endmodule

// File: rtl/des_ctrl.sv
module des_ctrl
    import des_pkg::*;
#(
    parameter int ROUNDS = 16,
    parameter int CTR_W  = $clog2(ROUNDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load,
    output logic             step,
    output logic             last,
    output logic [CTR_W-1:0] round_idx,
    output fsm_e             state
);

    localparam logic [CTR_W-1:0] LAST_IDX = CTR_W'(ROUNDS - 1);

    fsm_e             state_q, state_d;
    logic [CTR_W-1:0] rnd_q, rnd_d;

    always_comb begin
        state_d = state_q;
        rnd_d   = rnd_q;
        load    = 1'b0;
        step    = 1'b0;
        last    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin          // accept
                    load    = 1'b1;
                    rnd_d   = '0;
                    state_d = S_ROUND;
                end
            end
            S_ROUND: begin
                step = 1'b1;
                if (rnd_q == LAST_IDX) begin  // finish
                    last    = 1'b1;
                    state_d = S_IDLE;
                end else begin                // iterate
                    rnd_d = rnd_q + CTR_W'(1);
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rnd_q   <= '0;
        end else begin
            state_q <= state_d;
            rnd_q   <= rnd_d;
        end
    end

    assign round_idx = rnd_q;
    assign state     = state_q;

endmodule

// File: rtl/des_iter_engine.sv
module des_iter_engine
    import des_pkg::*;
#(
    parameter int ROUNDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  plaintext,
    input  logic [KEY_W-1:0]  key,
    output logic [BLK_W-1:0]  ciphertext,
    output logic              done
);

    localparam int CTR_W = $clog2(ROUNDS);

    logic              load, step, last;
    logic [CTR_W-1:0]  round_idx;
    fsm_e              fsm_state;
    logic [SUB_W-1:0]  subkey;
    logic [HALF_W-1:0] l_q, r_q, f_val, r_next;

    des_ctrl #(.ROUNDS(ROUNDS), .CTR_W(CTR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load      (load),
        .step      (step),
        .last      (last),
        .round_idx (round_idx),
        .state     (fsm_state)
    );

    des_key_sched #(.CTR_W(CTR_W)) u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .key_in    (key),
        .round_idx (round_idx),
        .subkey    (subkey)
    );

    des_round_fn u_fn (
        .r_in   (r_q),
        .subkey (subkey),
        .f_out  (f_val)
    );

    assign r_next = l_q ^ f_val;

    // Data halves
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
            r_q <= '0;
        end else if (load) begin
            {l_q, r_q} <= entry_perm(plaintext);
        end else if (step) begin
            l_q <= r_q;
            r_q <= r_next;
        end
    end

    // Outputs: final round skips the swap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ciphertext <= '0;
            done       <= 1'b0;
        end else begin
            done <= last;
            if (last) ciphertext <= exit_perm({r_next, r_q});
        end
    end

endmodule

// File: rtl/des_engine_checker.sv
module des_engine_checker
    import des_pkg::*;
#(
    parameter int ROUNDS = 16,
    parameter int CTR_W  = $clog2(ROUNDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             done,
    input  logic [63:0]      ciphertext,
    input  fsm_e             state,
    input  logic [CTR_W-1:0] rnd
);

    localparam int CW = CTR_W + 2;
    localparam logic [CTR_W-1:0] LAST_IDX = CTR_W'(ROUNDS - 1);

    logic [CW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_q <= '1;
        else if (start && state == S_IDLE) since_q <= '0;
        else if (since_q != '1) since_q <= since_q + CW'(1);
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!done && ciphertext == '0));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> since_q == CW'(ROUNDS));

    assert_busy_ignores_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ROUND && rnd != LAST_IDX) |=>
            (state == S_ROUND && rnd == $past(rnd) + CTR_W'(1)));

    assert_ct_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ciphertext));

endmodule

bind des_iter_engine des_engine_checker #(.ROUNDS(ROUNDS), .CTR_W(CTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .ciphertext (ciphertext),
    .state      (fsm_state),
    .rnd        (round_idx)
);

// File: tb/des_iter_engine_tb.sv
module des_iter_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] pt = '0;
    logic [63:0] key = '0;
    logic [63:0] ct;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    des_iter_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .plaintext(pt), .key(key), .ciphertext(ct), .done(done)
    );

    // Reference model state
    logic [63:0] nxt_exp = '0;
    string       nxt_tag = "R2";
    bit          m_busy = 0;
    int          m_cnt = 0;
    bit          exp_done = 0;
    logic [63:0] exp_ct = '0;
    logic [63:0] pend = '0;
    string       ptag = "R2";
    string       etag = "R2";
    bit          cmp_on = 0;

    task automatic check64(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; exp_done = 0; exp_ct = '0;
        end else begin
            exp_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 16) begin
                    exp_done = 1; exp_ct = pend; etag = ptag; m_busy = 0;
                end
            end else if (start) begin
                m_busy = 1; m_cnt = 0; pend = nxt_exp; ptag = nxt_tag;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check64(done == exp_done, "R3 done timing", {63'd0, done}, {63'd0, exp_done});
            if (exp_done) check64(ct === exp_ct, etag, ct, exp_ct);
            else          check64(ct === exp_ct, "R6 hold", ct, exp_ct);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic issue(input logic [63:0] p, input logic [63:0] k, input logic [63:0] e, input string tag);
        @(negedge clk);
        start = 1; pt = p; key = k; nxt_exp = e; nxt_tag = tag;
        @(negedge clk);
        start = 0;
        repeat (18) @(negedge clk);
    endtask

    localparam logic [63:0] K_A = 64'h0123456789ABCDEF;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check64(done == 1'b0, "R1 done in reset", {63'd0, done}, 64'd0);
        check64(ct == '0, "R1 ct in reset", ct, 64'd0);
        rst_n = 1;
        @(negedge clk);
        check64(done == 1'b0, "R1 done after reset", {63'd0, done}, 64'd0);
        check64(ct == '0, "R1 ct after reset", ct, 64'd0);
        cmp_on = 1;

        // R7: substitution addressing
        check64(des_pkg::sbox_val(7, 6'b011011) == 4'd14, "R7 box8 011011",
                {60'd0, des_pkg::sbox_val(7, 6'b011011)}, 64'd14);
        check64(des_pkg::sbox_val(0, 6'b110101) == 4'd3, "R7 box1 110101",
                {60'd0, des_pkg::sbox_val(0, 6'b110101)}, 64'd3);
        check64(des_pkg::sbox_val(0, 6'b000000) == 4'd14, "R7 box1 000000",
                {60'd0, des_pkg::sbox_val(0, 6'b000000)}, 64'd14);

        // R2 / R8: known encryptions
        issue(64'h4E6F772069732074, K_A, 64'h3FA40E8A984D4815, "R2 vec1");
        issue(64'h68652074696D6520, K_A, 64'h6A271787AB8883F9, "R2 vec2");
        issue(64'h666F7220616C6C20, K_A, 64'h893D51EC4B563B53, "R8 vec3");
        issue(64'h0123456789ABCDEF, 64'h133457799BBCDFF1, 64'h85E813540F0AB405, "R8 vec4");
        issue(64'h0, 64'h0, 64'h8CA64DE9C1B123A7, "R2 zero");

        // R5: parity bits flipped
        issue(64'h4E6F772069732074, K_A ^ 64'h0101010101010101, 64'h3FA40E8A984D4815, "R5 parity");

        // R4: start while busy is ignored
        @(negedge clk);
        start = 1; pt = 64'h68652074696D6520; key = K_A;
        nxt_exp = 64'h6A271787AB8883F9; nxt_tag = "R4 busy";
        @(negedge clk);
        start = 0;
        repeat (5) @(negedge clk);
        start = 1; pt = 64'h0; key = 64'h0; nxt_exp = 64'hDEAD; nxt_tag = "R4 ghost";
        @(negedge clk);
        start = 0; pt = 64'h0123456789ABCDEF;
        repeat (20) @(negedge clk);

        // R3/R4: start held high, completion coincides with a request
        @(negedge clk);
        start = 1; pt = 64'h666F7220616C6C20; key = K_A;
        nxt_exp = 64'h893D51EC4B563B53; nxt_tag = "R3 held";
        repeat (40) @(negedge clk);
        start = 0;
        repeat (25) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule